// File: doc/BRIEF.md
# LIN Controller Control and Status Logic

This block is the host-facing register logic of a LIN bus controller. It sits between a host register port and a protocol engine. The host writes a control word and reads back three registers: control, state and error. The protocol engine reports one-cycle event pulses: frame completed, errors carried as a four-bit code, identifier received, wakeup sent, wakeup received, and abort. The block drives a start request, a wakeup request and two mode bits (direction and master select) to the engine, and raises a single interrupt line.

Each flag follows its own rule. Some are set by an event and cleared by a write-one action bit. Others are set by the host and cleared by the core. The error-reset action clears the whole error register, the error summary, the aborted flag and the wakeup flag. An event that lands in the same cycle as a clear action takes priority. There is no data stream, so every pin is a plain level or pulse. Writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`.

Register addresses: 0 = control, 1 = state, 2 = error, 3 = reserved (reads 0). Control bits: 0 = start, 1 = wakeup request, 2 = error-reset action, 3 = interrupt-reset action, 4 = data-request acknowledge action, 5 = direction (1 transmit, 0 receive), 6 = master select. State bits: 0 = complete, 1 = wakeup, 2 = error summary, 3 = interrupt, 4 = data request, 5 = aborted.

Top module: `lin_csr`

## Requirements
- R1: A control write with bit 0 = 1 and bit 6 = 1 sets `start_req` from the next cycle. If bit 6 of that write is 0, `start_req` stays 0. `start_req` clears after a frame-done pulse or an accepted error. That clear wins over a start write in the same cycle.
- R2: A frame-done pulse sets the complete flag (state bit 0). An accepted start write clears it. If both happen in the same cycle, the set wins.
- R3: The interrupt flag (state bit 3) and `irq` are set by any of these: frame done, an accepted error, an identifier in slave mode, a wakeup sent or received, or an abort. A control write with bit 3 = 1 clears both.
- R4: If an interrupt-setting event arrives in the same cycle as an interrupt-reset write, the interrupt flag stays set.
- R5: A control write with bit 2 = 1 clears the error register, the error summary, the aborted flag and the wakeup flag. An error or wakeup event in the same cycle wins for the bits it sets. Control bits 2, 3 and 4 always read as 0.
- R6: The error code bits are: bit 3 identifier parity, bit 2 timeout, bit 1 checksum, bit 0 bit error. An error pulse ORs the accepted bits into the error register and sets the error summary (state bit 2). A parity bit is ignored while master select is 1.
- R7: In slave mode (master select = 0), an identifier pulse sets the data-request flag (state bit 4). In master mode the pulse changes nothing. A control write with bit 4 = 1 clears the flag.
- R8: A wakeup-sent or wakeup-received pulse sets the wakeup flag (state bit 1). A control write with bit 1 = 1 sets `wake_req`. A wakeup-sent pulse clears `wake_req`.
- R9: Control bits 5 and 6 are stored on every control write. They drive `tx_dir` and `master` and read back in place. Writes to the state, error or reserved addresses change nothing.
- R10: An abort pulse sets the aborted flag (state bit 5). After reset, all three registers read 0, and `irq`, `start_req` and `wake_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| ev_done | input | 1 | Frame completed without error |
| ev_err | input | 1 | Error pulse qualifier |
| ev_err_code | input | 4 | Error bits, valid with ev_err |
| ev_id | input | 1 | Identifier received |
| ev_wake_tx | input | 1 | Wakeup signal sent |
| ev_wake_rx | input | 1 | Wakeup signal received |
| ev_abort | input | 1 | Transfer aborted |
| start_req | output | 1 | Start request to the engine |
| wake_req | output | 1 | Wakeup request to the engine |
| tx_dir | output | 1 | Direction: 1 transmit, 0 receive |
| master | output | 1 | Master select |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every event input is a clean one-cycle pulse that is low during reset, and that `ev_err_code` matters only while `ev_err` is high. The bench drives every input on the falling edge and returns each pulse low one cycle later. It overlaps events with writes only in the deliberate same-cycle cases, so every asserted priority is reached with legal stimulus.

// File: rtl/lin_csr_pkg.sv
package lin_csr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int ERR_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_STATE = 2'd1,
    A_ERR   = 2'd2,
    A_RSVD  = 2'd3
  } reg_addr_e;

  // control word bit positions
  localparam int C_START = 0;
  localparam int C_WAKE  = 1;
  localparam int C_CLRE  = 2;
  localparam int C_CLRI  = 3;
  localparam int C_ACK   = 4;
  localparam int C_DIR   = 5;
  localparam int C_MST   = 6;

  // error code bit positions
  localparam int E_PAR = 3;

  typedef struct packed {
    logic aborted;
    logic dreq;
    logic irq;
    logic err;
    logic wake;
    logic cmpl;
  } state_t;
endpackage

// File: rtl/lin_csr_ctrl.sv
module lin_csr_ctrl
  import lin_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [C_MST:0]    wdat,
  input  logic              end_evt,
  input  logic              wake_sent,
  output logic              start_acc,
  output logic              start_req,
  output logic              wake_req,
  output logic              tx_dir,
  output logic              master
);
  assign start_acc = wr_ctrl && wdat[C_START] && wdat[C_MST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_req <= 1'b0;
      wake_req  <= 1'b0;
      tx_dir    <= 1'b0;
      master    <= 1'b0;
    end else begin
      if (end_evt)        start_req <= 1'b0;
      else if (start_acc) start_req <= 1'b1;
      if (wake_sent)                   wake_req <= 1'b0;
      else if (wr_ctrl && wdat[C_WAKE]) wake_req <= 1'b1;
      if (wr_ctrl) begin
        tx_dir <= wdat[C_DIR];
        master <= wdat[C_MST];
      end
    end
  end

  AST_START_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !start_req); // R1
  AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_sent |=> !wake_req); // R8
endmodule

// File: rtl/lin_csr_flags.sv
module lin_csr_flags
  import lin_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             start_acc,
  input  logic             clr_irq,
  input  logic             clr_err,
  input  logic             ack,
  input  logic             ev_done,
  input  logic             ev_err,
  input  logic [ERR_W-1:0] ev_err_code,
  input  logic             ev_id,
  input  logic             ev_wake_tx,
  input  logic             ev_wake_rx,
  input  logic             ev_abort,
  output logic             err_any,
  output state_t           st,
  output logic [ERR_W-1:0] err_q
);
  localparam logic [ERR_W-1:0] PAR_MASK = ERR_W'(1) << E_PAR;

  logic [ERR_W-1:0] err_acc;
  logic             id_acc, wake_any, irq_set;

  assign err_acc  = ev_err ? (ev_err_code & ~(master ? PAR_MASK : '0)) : '0;
  assign err_any  = |err_acc;
  assign id_acc   = ev_id && !master;
  assign wake_any = ev_wake_tx || ev_wake_rx;
  assign irq_set  = ev_done || err_any || id_acc || wake_any || ev_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= '0;
      err_q <= '0;
    end else begin
      if (ev_done)        st.cmpl <= 1'b1;
      else if (start_acc) st.cmpl <= 1'b0;

      if (irq_set)      st.irq <= 1'b1;
      else if (clr_irq) st.irq <= 1'b0;

      if (id_acc)   st.dreq <= 1'b1;
      else if (ack) st.dreq <= 1'b0;

      err_q      <= (clr_err ? '0 : err_q) | err_acc;
      st.err     <= (clr_err ? 1'b0 : st.err) | err_any;
      st.wake    <= (clr_err ? 1'b0 : st.wake) | wake_any;
      st.aborted <= (clr_err ? 1'b0 : st.aborted) | ev_abort;
    end
  end

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> st.cmpl); // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st.irq && !clr_irq |=> st.irq); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> st.irq); // R4
  AST_ERR_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err && !ev_err && !wake_any |=> (err_q == '0) && !st.err && !st.wake); // R5
  AST_NO_PAR_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q[E_PAR]) |-> !$past(master)); // R6
  AST_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != '0) |-> st.err); // R6
endmodule

// File: rtl/lin_csr_rdmux.sv
module lin_csr_rdmux
  import lin_csr_pkg::*;
(
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              start_req,
  input  logic              wake_req,
  input  logic              tx_dir,
  input  logic              master,
  input  state_t            st,
  input  logic [ERR_W-1:0]  err_q,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      A_CTRL: begin
        rd_data[C_START] = start_req;
        rd_data[C_WAKE]  = wake_req;
        rd_data[C_DIR]   = tx_dir;
        rd_data[C_MST]   = master;
      end
      A_STATE: rd_data[$bits(state_t)-1:0] = st;
      A_ERR:   rd_data[ERR_W-1:0] = err_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/lin_csr.sv
module lin_csr
  import lin_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_done,
  input  logic              ev_err,
  input  logic [ERR_W-1:0]  ev_err_code,
  input  logic              ev_id,
  input  logic              ev_wake_tx,
  input  logic              ev_wake_rx,
  input  logic              ev_abort,
  output logic              start_req,
  output logic              wake_req,
  output logic              tx_dir,
  output logic              master,
  output logic              irq
);
  logic   wr_ctrl, start_acc, err_any, end_evt;
  logic   unused_wr_hi;
  state_t st;
  logic [ERR_W-1:0] err_q;

  assign wr_ctrl      = wr_en && (reg_addr_e'(wr_addr) == A_CTRL);
  assign end_evt      = ev_done || err_any;
  assign unused_wr_hi = ^wr_data[DATA_W-1:C_MST+1];

  lin_csr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdat(wr_data[C_MST:0]),
    .end_evt(end_evt), .wake_sent(ev_wake_tx), .start_acc(start_acc),
    .start_req(start_req), .wake_req(wake_req), .tx_dir(tx_dir), .master(master)
  );

  lin_csr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .master(master), .start_acc(start_acc),
    .clr_irq(wr_ctrl && wr_data[C_CLRI]), .clr_err(wr_ctrl && wr_data[C_CLRE]),
    .ack(wr_ctrl && wr_data[C_ACK]), .ev_done(ev_done), .ev_err(ev_err),
    .ev_err_code(ev_err_code), .ev_id(ev_id), .ev_wake_tx(ev_wake_tx),
    .ev_wake_rx(ev_wake_rx), .ev_abort(ev_abort), .err_any(err_any),
    .st(st), .err_q(err_q)
  );

  lin_csr_rdmux u_rd (
    .rd_addr(rd_addr), .start_req(start_req), .wake_req(wake_req),
    .tx_dir(tx_dir), .master(master), .st(st), .err_q(err_q), .rd_data(rd_data)
  );

  assign irq = st.irq;

  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> st.aborted && irq); // R10
endmodule

// File: tb/tb_lin_csr.sv
module tb_lin_csr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, ev_done = 0, ev_err = 0, ev_id = 0, ev_wake_tx = 0, ev_wake_rx = 0, ev_abort = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [3:0] ev_err_code = 0;
  logic start_req, wake_req, tx_dir, master, irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  lin_csr dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_done(ev_done), .ev_err(ev_err),
    .ev_err_code(ev_err_code), .ev_id(ev_id), .ev_wake_tx(ev_wake_tx),
    .ev_wake_rx(ev_wake_rx), .ev_abort(ev_abort), .start_req(start_req),
    .wake_req(wake_req), .tx_dir(tx_dir), .master(master), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic chk_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d); chk(tag, d, exp);
  endtask

  task automatic idle();
    wr_en = 0; ev_done = 0; ev_err = 0; ev_err_code = 0; ev_id = 0;
    ev_wake_tx = 0; ev_wake_rx = 0; ev_abort = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk_reg("R10 ctrl reset", 0, 8'h00);
    chk_reg("R10 state reset", 1, 8'h00);
    chk_reg("R10 err reset", 2, 8'h00);
    chk("R10 outs reset", {5'b0, irq, start_req, wake_req}, 8'h00);
  endtask

  task automatic t_start();
    wr(0, 8'h01);
    chk("R1 start ignored in slave", {7'b0, start_req}, 8'h00);
    wr(0, 8'h41);
    chk("R1 start set", {7'b0, start_req}, 8'h01);
    chk_reg("R9 ctrl readback", 0, 8'h41);
    @(negedge clk); ev_done = 1; @(negedge clk); idle();
    chk("R1 start cleared by done", {7'b0, start_req}, 8'h00);
    chk_reg("R2 complete and R3 irq", 1, 8'h09);
    wr(0, 8'h48);
    chk("R3 irq cleared", {7'b0, irq}, 8'h00);
    chk_reg("R2 complete held", 1, 8'h01);
    wr(0, 8'h41);
    chk_reg("R2 complete cleared by start", 1, 8'h00);
    @(negedge clk); ev_done = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h41;
    @(negedge clk); idle();
    chk("R1 clear wins over start", {7'b0, start_req}, 8'h00);
    chk_reg("R2 set wins over start", 1, 8'h09);
    wr(0, 8'h48);
  endtask

  task automatic t_err();
    wr(0, 8'h41);
    @(negedge clk); ev_err = 1; ev_err_code = 4'hF; @(negedge clk); idle();
    chk_reg("R6 parity dropped in master", 2, 8'h07);
    chk_reg("R6 summary and irq", 1, 8'h0C);
    chk("R1 start cleared by error", {7'b0, start_req}, 8'h00);
    wr(0, 8'h44);
    chk_reg("R5 err cleared", 2, 8'h00);
    chk_reg("R5 summary cleared irq kept", 1, 8'h08);
    wr(0, 8'h48);
    chk_reg("R3 state clear", 1, 8'h00);
  endtask

  task automatic t_race();
    @(negedge clk); ev_abort = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h08;
    @(negedge clk); idle();
    chk_reg("R4 irq kept, R10 aborted", 1, 8'h28);
    @(negedge clk); ev_err = 1; ev_err_code = 4'h2; wr_en = 1; wr_addr = 0; wr_data = 8'h04;
    @(negedge clk); idle();
    chk_reg("R5 event beats clear", 2, 8'h02);
    wr(0, 8'h0C);
    chk_reg("R5 aborted cleared", 1, 8'h00);
    chk_reg("R5 err empty", 2, 8'h00);
    chk_reg("R5 action bits read 0", 0, 8'h00);
  endtask

  task automatic t_slave();
    @(negedge clk); ev_id = 1; @(negedge clk); idle();
    chk_reg("R7 data request", 1, 8'h18);
    wr(0, 8'h18);
    chk_reg("R7 ack clears", 1, 8'h00);
    @(negedge clk); ev_err = 1; ev_err_code = 4'h8; @(negedge clk); idle();
    chk_reg("R6 parity in slave", 2, 8'h08);
    wr(0, 8'h0C);
    wr(0, 8'h40);
    @(negedge clk); ev_id = 1; @(negedge clk); idle();
    chk_reg("R7 id ignored in master", 1, 8'h00);
    chk("R7 no irq in master", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_wake();
    wr(0, 8'h42);
    chk_reg("R8 wake request", 0, 8'h42);
    @(negedge clk); ev_wake_tx = 1; @(negedge clk); idle();
    chk("R8 wake_req dropped", {7'b0, wake_req}, 8'h00);
    chk_reg("R8 wake sent flag", 1, 8'h0A);
    wr(0, 8'h4C);
    chk_reg("R5 wake cleared", 1, 8'h00);
    @(negedge clk); ev_wake_rx = 1; @(negedge clk); idle();
    chk_reg("R8 wake received flag", 1, 8'h0A);
    wr(0, 8'h0C);
  endtask

  task automatic t_regs();
    wr(0, 8'h7C);
    chk_reg("R9 mode bits", 0, 8'h60);
    chk("R9 outputs", {6'b0, tx_dir, master}, 8'h03);
    wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF);
    chk_reg("R9 state not writable", 1, 8'h00);
    chk_reg("R9 err not writable", 2, 8'h00);
    chk_reg("R9 rsvd reads 0", 3, 8'h00);
    chk_reg("R9 ctrl untouched", 0, 8'h60);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_start(); t_err(); t_race(); t_slave(); t_wake(); t_regs();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule